// File: doc/BRIEF.md
# Self-Correcting Johnson Phase Generator

This block is a twisted-ring counter of `WIDTH` flops. On every clock edge with the advance input high, the register shifts right by one place. The inverted bit that leaves the low end enters at the top. This walks the register through `2*WIDTH` states, and exactly one bit flips on each step. The raw register is brought out so that any single bit can serve as a divided clock with an even duty cycle.

A `2*WIDTH`-bit phase vector is also produced. Each phase bit comes from a single two-input gate on one pair of register bits, so exactly one phase is active in each legal state. A sequencer or timeslot rotator can use these bits directly as enables.

A legality checker runs every cycle. A value is legal when, along the register, at most one pair of neighbouring bits differs. All other values are illegal; they can arise from an upset or an uninitialised power-up. While the value is illegal, the block raises a flag and silences the phase vector. The next enabled edge then loads all-zeros, so the counter recovers without a reset.

Top module: `jphase_gen`

## Requirements
- R1: A clock edge with `rst` high loads all-zeros into `count`, whatever `adv` is and whatever the current value (legal or not). After it, `bad_state` is 0 and `phase` equals 1 (only bit 0 set).
- R2: An edge with `rst` low, `adv` high and a legal current value loads `{~count[0], count[WIDTH-1:1]}`. From all-zeros with WIDTH=4 the values are 1000, 1100, 1110, 1111, 0111, 0011, 0001, then 0000.
- R3: An edge with `rst` low and `adv` low leaves `count` unchanged.
- R4: Each legal enabled step changes exactly one bit of `count`, and `2*WIDTH` enabled steps from all-zeros return to all-zeros.
- R5: For a legal value reached by k enabled steps from all-zeros (0 <= k < 2*WIDTH), `phase` has only bit k set. Bit 0 decodes MSB=0 and LSB=0. Bit WIDTH decodes MSB=1 and LSB=1. For 1 <= k < WIDTH, bit k is `count[WIDTH-k] & ~count[WIDTH-k-1]`, and bit WIDTH+k is `~count[WIDTH-k] & count[WIDTH-k-1]`.
- R6: With `adv` held high, over any `2*WIDTH` consecutive edges each bit of `count` is high for exactly WIDTH cycles and changes value exactly twice.
- R7: A value is legal when at most one position i (1 <= i < WIDTH) has `count[i] != count[i-1]`. `bad_state` is 1 exactly when the present value is illegal, with no clock delay.
- R8: While the value is illegal, `phase` is all-zeros; `phase` never has more than one bit set.
- R9: An edge with `rst` low, `adv` high and an illegal current value loads all-zeros, so recovery takes one enabled edge.
- R10: An illegal value with `adv` low and `rst` low is held, and `bad_state` stays 1 until an enabled or reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset to all-zeros |
| adv | input | 1 | Advance enable for one step per edge |
| count | output | WIDTH | Twisted-ring register, usable as divided clock bits |
| phase | output | 2*WIDTH | One-hot decoded phase, all-zeros when illegal |
| bad_state | output | 1 | High while the register holds an illegal value |

## Verification
Two functions can meet in one cycle: recovery from an illegal value and the other two edge actions, which are the advance gating and the reset. The bench places every one of the `2^WIDTH` register values into the counter through the reset path. For each illegal value it first holds with advance low and expects the value and flag to persist. It then gives one enabled edge and expects all-zeros. A further case asserts reset with advance low on an illegal value and expects all-zeros, which shows that reset wins even without an enable. The scoreboard judges every edge against a model computed from the requirements, and the flag and phase outputs are compared combinationally right after each injection.

// File: rtl/jphase_pkg.sv
package jphase_pkg;

    // Kind of update chosen for the next register value
    typedef enum logic [1:0] {
        STEP_HOLD    = 2'd0,
        STEP_SHIFT   = 2'd1,
        STEP_RECOVER = 2'd2,
        STEP_RESET   = 2'd3
    } step_e;

endpackage

// File: rtl/jphase_legal.sv
module jphase_legal #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] ring,
    output logic             legal
);
    localparam int NEDGE = WIDTH - 1;

    // One flag per neighbouring pair whose bits differ
    logic [NEDGE-1:0] diff;

    for (genvar i = 1; i < WIDTH; i++) begin : g_edge
        assign diff[i-1] = ring[i] ^ ring[i-1];
    end

    // Legal when there is at most one boundary along the register
    always_comb begin
        legal = $onehot0(diff);
    end

endmodule

// File: rtl/jphase_core.sv
module jphase_core
    import jphase_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             legal,
    output logic [WIDTH-1:0] ring
);
    typedef struct packed {
        logic [WIDTH-1:0] ring;
    } state_t;

    state_t state_d, state_q;
    step_e  step;

    always_comb begin
        state_d = state_q;
        if (rst) begin
            step = STEP_RESET;
        end else if (!adv) begin
            step = STEP_HOLD;
        end else if (!legal) begin
            step = STEP_RECOVER;
        end else begin
            step = STEP_SHIFT;
        end

        unique case (step)
            STEP_RESET,
            STEP_RECOVER: state_d.ring = '0;
            STEP_SHIFT:   state_d.ring = {~state_q.ring[0], state_q.ring[WIDTH-1:1]};
            default:      state_d.ring = state_q.ring;
        endcase
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign ring = state_q.ring;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(ring)) else $error("hold failed"); // R3

    AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv && legal) |=> ($countones(ring ^ $past(ring)) == 1)) else $error("step flipped other than one bit"); // R4

    AST_RECOVER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (adv && !legal) |=> (ring == '0)) else $error("no recovery to zero"); // R9

endmodule

// File: rtl/jphase_decode.sv
module jphase_decode #(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    input  logic [WIDTH-1:0]   ring,
    input  logic               legal,
    output logic [2*WIDTH-1:0] phase
);
    localparam int NPH = 2 * WIDTH;

    logic [NPH-1:0] raw;

    // Ends of the sequence: empty and full register
    assign raw[0]     = ~ring[WIDTH-1] & ~ring[0];
    assign raw[WIDTH] =  ring[WIDTH-1] &  ring[0];

    // Filling and emptying states: one gate on the boundary pair
    for (genvar k = 1; k < WIDTH; k++) begin : g_pair
        assign raw[k]       =  ring[WIDTH-k] & ~ring[WIDTH-k-1];
        assign raw[WIDTH+k] = ~ring[WIDTH-k] &  ring[WIDTH-k-1];
    end

    always_comb begin
        phase = legal ? raw : '0;
    end

    AST_PHASE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        legal |-> $onehot(phase)) else $error("legal state without single phase"); // R5

    AST_PHASE_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        $onehot0(phase)) else $error("phases overlap"); // R8

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (adv && legal && phase[NPH-1]) |=> phase[0]) else $error("last phase did not wrap"); // R4

endmodule

// File: rtl/jphase_gen.sv
module jphase_gen #(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    output logic [WIDTH-1:0]   count,
    output logic [2*WIDTH-1:0] phase,
    output logic               bad_state
);
    logic [WIDTH-1:0] ring;
    logic             legal;

    jphase_core #(.WIDTH(WIDTH)) u_core (
        .clk   (clk),
        .rst   (rst),
        .adv   (adv),
        .legal (legal),
        .ring  (ring)
    );

    jphase_legal #(.WIDTH(WIDTH)) u_legal (
        .ring  (ring),
        .legal (legal)
    );

    jphase_decode #(.WIDTH(WIDTH)) u_decode (
        .clk   (clk),
        .rst   (rst),
        .adv   (adv),
        .ring  (ring),
        .legal (legal),
        .phase (phase)
    );

    assign count     = ring;
    assign bad_state = ~legal;

    AST_ONE_EDGE_RECOVERY: assert property (@(posedge clk) disable iff (rst)
        (adv && bad_state) |=> !bad_state) else $error("still illegal after enabled edge"); // R9

    AST_ILLEGAL_HELD: assert property (@(posedge clk) disable iff (rst)
        (!adv && bad_state) |=> bad_state) else $error("illegal value left without enable"); // R10

endmodule

// File: tb/jphase_gen_test.sv
`timescale 1ns/1ps
module jphase_gen_test;
    localparam int W   = 4;
    localparam int NPH = 2 * W;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           en  = 1'b0;
    logic [W-1:0]   count;
    logic [NPH-1:0] phase;
    logic           bad_state;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [W-1:0] model = '0;
    logic [W-1:0] exp_ring_q[$];
    string        exp_tag_q[$];

    always #4 clk = ~clk;

    jphase_gen #(.WIDTH(W)) uut (
        .clk       (clk),
        .rst       (rst),
        .adv       (en),
        .count     (count),
        .phase     (phase),
        .bad_state (bad_state)
    );

    // Legality from R7: at most one differing neighbour pair
    function automatic bit is_legal(logic [W-1:0] v);
        int n = 0;
        for (int i = 1; i < W; i++) if (v[i] != v[i-1]) n++;
        return n <= 1;
    endfunction

    // Expected phase from R5/R8: index of v along the sequence from zero
    function automatic logic [NPH-1:0] exp_phase(logic [W-1:0] v);
        logic [NPH-1:0] p = '0;
        logic [W-1:0]   s = '0;
        if (!is_legal(v)) return '0;
        for (int k = 0; k < NPH; k++) begin
            if (s == v) p[k] = 1'b1;
            s = {~s[0], s[W-1:1]};
        end
        return p;
    endfunction

    function automatic logic [W-1:0] nxt(logic [W-1:0] v, bit r, bit e);
        if (r) return '0;
        if (!e) return v;
        if (!is_legal(v)) return '0;
        return {~v[0], v[W-1:1]};
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // Driver: apply inputs away from the edge and queue the expected result
    task automatic drive(bit r, bit e, string tag);
        @(negedge clk);
        rst   = r;
        en    = e;
        model = nxt(model, r, e);
        exp_ring_q.push_back(model);
        exp_tag_q.push_back(tag);
    endtask

    // Place any value in the register right after a reset edge
    task automatic inject(logic [W-1:0] v, string tag);
        drive(1'b1, 1'b0, "R1");
        @(negedge clk);
        rst = 1'b0;
        en  = 1'b0;
        force uut.u_core.state_q = v;
        #1;
        release uut.u_core.state_q;
        model = v;
        #1;
        chk(bad_state == !is_legal(v), "R7", "flag", 64'(bad_state), 64'(!is_legal(v)));
        chk(phase == exp_phase(v), tag, "phase", 64'(phase), 64'(exp_phase(v)));
    endtask

    // Monitor: compare each queued expectation after its edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_ring_q.size() > 0) begin
                logic [W-1:0] er;
                string        tg;
                er = exp_ring_q.pop_front();
                tg = exp_tag_q.pop_front();
                chk(count == er, tg, "count", 64'(count), 64'(er));
                chk(phase == exp_phase(er), tg, "phase", 64'(phase), 64'(exp_phase(er)));
                chk(bad_state == !is_legal(er), tg, "flag", 64'(bad_state), 64'(!is_legal(er)));
            end
        end
    end

    initial begin
        int highs [W];
        int flips [W];
        logic [W-1:0] prev;

        // R1: reset state
        drive(1'b1, 1'b0, "R1");
        drive(1'b1, 1'b1, "R1");
        @(posedge clk); #3;
        chk(phase == NPH'(1), "R1", "phase after reset", 64'(phase), 64'd1);

        // R2: first step from zero sets the top bit
        drive(1'b0, 1'b1, "R2");
        @(posedge clk); #3;
        chk(count == (W'(1) << (W-1)), "R2", "first step", 64'(count), 64'(W'(1) << (W-1)));
        for (int c = 1; c < NPH; c++) drive(1'b0, 1'b1, "R2");

        // R4: second full lap including wrap
        for (int c = 0; c < NPH; c++) drive(1'b0, 1'b1, "R4");

        // R3: enable gaps interleaved with steps
        for (int c = 0; c < 3 * NPH; c++) drive(1'b0, (c % 3) == 0, "R3");

        // R6: duty and period of every bit
        drive(1'b1, 1'b0, "R1");
        @(posedge clk); #3;
        prev = count;
        for (int i = 0; i < W; i++) begin highs[i] = 0; flips[i] = 0; end
        for (int c = 0; c < NPH; c++) begin
            drive(1'b0, 1'b1, "R6");
            @(posedge clk); #3;
            for (int i = 0; i < W; i++) begin
                highs[i] += int'(count[i]);
                flips[i] += int'(count[i] != prev[i]);
            end
            prev = count;
        end
        for (int i = 0; i < W; i++) begin
            chk(highs[i] == W, "R6", "high cycles", 64'(highs[i]), 64'(W));
            chk(flips[i] == 2, "R6", "changes", 64'(flips[i]), 64'd2);
        end

        // R7-R10 and R5: every register value, legal or not
        for (int v = 0; v < (1 << W); v++) begin
            inject(W'(v), is_legal(W'(v)) ? "R5" : "R8");
            if (!is_legal(W'(v))) begin
                drive(1'b0, 1'b0, "R10");
                drive(1'b0, 1'b0, "R10");
                drive(1'b0, 1'b1, "R9");
                drive(1'b0, 1'b1, "R9");
            end else begin
                drive(1'b0, 1'b1, "R5");
                drive(1'b0, 1'b1, "R5");
            end
        end

        // R1: reset with enable low wins over a held illegal value
        inject(W'(4'b0110), "R8");
        drive(1'b0, 1'b0, "R10");
        drive(1'b1, 1'b0, "R1");
        drive(1'b0, 1'b1, "R2");

        @(posedge clk); #3;
        @(posedge clk); #3;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all act=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule